// File: doc/BRIEF.md
# Serial Flash Status and Write-Enable Controller

This block keeps the eight-bit status byte of a serial flash device and the write-permission state behind it. A command decoder upstream hands it one-cycle event pulses: write-enable, write-disable, modify requests with an operation code, suspend, resume, and the end of an internal write. The block decides whether a modify request may proceed, reports that decision on the same cycle, and updates the status byte on the next clock edge. The erase and program timing lives elsewhere; a separate engine raises `wr_done` when an internal write finishes.

Two resets exist. `rst` is a soft reset that returns the volatile state to idle but keeps the protection freeze and the identifier lock. `por` models a power cycle: it clears the protection freeze as well, and reloads the identifier lock from `nv_sid_locked`, a flag kept in non-volatile storage. The block raises `sid_commit` when an identifier lockout is accepted, so that this storage can be updated and the lock survives later power cycles.

Operation codes on `mod_op`: 0 page program, 1 sector erase, 2 block erase, 3 chip erase, 4 identifier program, 5 protection-register write, 6 protection freeze, 7 identifier lockout. Codes 0 to 4 start an internal write; codes 1 to 3 are erase kind, 0 and 4 are program kind. Codes 5 to 7 complete at once.

Top module: `flash_status_ctrl`

## Requirements
- R1: After `por`, status bits 7, 4, 3, 2 and 1 are 0 and bit 5 equals `nv_sid_locked`; bits 0 and 6 always read 0.
- R2: `ev_wren` sets status bit 1 (write-enable latch) on the next edge; `ev_wrdi` clears it.
- R3: A modify request is rejected (`mod_accept` low, status unchanged) when bit 1 is 0 or bit 7 (busy) is 1.
- R4: An accepted code 0 to 4 sets bit 7 on the next edge and leaves bit 1 set; `wr_done` while busy clears both bit 7 and bit 1.
- R5: An accepted code 5, 6 or 7 clears bit 1 on the next edge without setting bit 7.
- R6: `ev_suspend` while an erase-kind write runs sets bit 2; while a program-kind write runs it sets bit 3; either way bits 7 and 1 clear. A suspend of a kind whose suspended bit is already set is ignored.
- R7: `ev_resume` while idle restarts the program-kind write first if bit 3 is set (clearing bit 3), otherwise the erase-kind write if bit 2 is set (clearing bit 2), and sets bit 7; while busy it is ignored.
- R8: An accepted code 6 sets bit 4; only `por` clears it; while bit 4 is 1, codes 5 and 6 are rejected.
- R9: An accepted code 7 sets bit 5 and pulses `sid_commit` in the request cycle; bit 5 never falls except through `por` with `nv_sid_locked` low; while bit 5 is 1, codes 4 and 7 are rejected.
- R10: `write_ok` is high exactly when bit 1 is 1 and bit 7 is 0.
- R11: `rst` clears bits 1, 2, 3 and 7 and keeps bits 4 and 5.
- R12: `wr_done`, `ev_suspend` while idle, and `ev_resume` with no suspended write leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, active high |
| por | input | 1 | Synchronous power-cycle reset, active high |
| nv_sid_locked | input | 1 | Non-volatile identifier lock flag, loaded on `por` |
| ev_wren | input | 1 | Write-enable event pulse |
| ev_wrdi | input | 1 | Write-disable event pulse |
| mod_req | input | 1 | Modify request pulse |
| mod_op | input | 3 | Operation code of the modify request |
| wr_done | input | 1 | End of the internal write |
| ev_suspend | input | 1 | Suspend event pulse |
| ev_resume | input | 1 | Resume event pulse |
| status | output | 8 | Status byte |
| write_ok | output | 1 | Modify commands currently permitted |
| mod_accept | output | 1 | Request accepted, same cycle as `mod_req` |
| sid_commit | output | 1 | Identifier lockout accepted, store the lock |

## Verification
The bench drives nested suspends, an erase suspended and then a program started and suspended inside it, to show that resume picks the program first; a design with the order reversed would restart the erase and leave bit 3 stuck. It sends freeze and lockout requests before and after soft and power-cycle resets, where a design that let `rst` drop bit 4 or that let `por` forget the identifier lock would report an open register. Completion, suspend and resume pulses arrive with nothing to act on, which catches a latch cleared by a stray `wr_done`, and a long random run with one event per cycle compares every status byte against a bench model.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int STATUS_W = 8;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PAGE_PROG   = 3'd0,
        OP_SECT_ERASE  = 3'd1,
        OP_BLOCK_ERASE = 3'd2,
        OP_CHIP_ERASE  = 3'd3,
        OP_SID_PROG    = 3'd4,
        OP_PROT_WRITE  = 3'd5,
        OP_PROT_FREEZE = 3'd6,
        OP_SID_LOCKOUT = 3'd7
    } mod_op_e;

    typedef enum logic {
        WK_PROG  = 1'b0,
        WK_ERASE = 1'b1
    } wr_kind_e;

    // Packed MSB first: busy is bit 7, reserved bit 0 is the LSB.
    typedef struct packed {
        logic busy;
        logic rsv6;
        logic sid_locked;
        logic prot_frozen;
        logic prog_susp;
        logic erase_susp;
        logic wel;
        logic rsv0;
    } status_t;

    function automatic logic op_is_long(mod_op_e op);
        return (op == OP_PAGE_PROG) || (op == OP_SECT_ERASE) ||
               (op == OP_BLOCK_ERASE) || (op == OP_CHIP_ERASE) ||
               (op == OP_SID_PROG);
    endfunction

    function automatic wr_kind_e op_kind(mod_op_e op);
        if ((op == OP_SECT_ERASE) || (op == OP_BLOCK_ERASE) || (op == OP_CHIP_ERASE))
            return WK_ERASE;
        return WK_PROG;
    endfunction

    function automatic logic op_hits_sid(mod_op_e op);
        return (op == OP_SID_PROG) || (op == OP_SID_LOCKOUT);
    endfunction

    function automatic logic op_hits_prot(mod_op_e op);
        return (op == OP_PROT_WRITE) || (op == OP_PROT_FREEZE);
    endfunction

endpackage

// File: rtl/fsc_cmd_gate.sv
module fsc_cmd_gate
    import fsc_pkg::*;
(
    input  logic     mod_req,
    input  mod_op_e  mod_op,
    input  logic     wel,
    input  logic     busy,
    input  logic     prot_frozen,
    input  logic     sid_locked,
    output logic     accept,
    output logic     start_long,
    output wr_kind_e start_kind,
    output logic     imm_done,
    output logic     freeze_set,
    output logic     sid_set
);

    logic blocked_target;

    always_comb begin
        blocked_target = (op_hits_sid(mod_op) && sid_locked) ||
                         (op_hits_prot(mod_op) && prot_frozen);
        accept     = mod_req && wel && !busy && !blocked_target;
        start_long = accept && op_is_long(mod_op);
        start_kind = op_kind(mod_op);
        imm_done   = accept && !op_is_long(mod_op);
        freeze_set = accept && (mod_op == OP_PROT_FREEZE);
        sid_set    = accept && (mod_op == OP_SID_LOCKOUT);
    end

endmodule

// File: rtl/fsc_write_track.sv
module fsc_write_track
    import fsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_all,
    input  logic     start_long,
    input  wr_kind_e start_kind,
    input  logic     wr_done,
    input  logic     ev_suspend,
    input  logic     ev_resume,
    output logic     busy,
    output logic     erase_susp,
    output logic     prog_susp,
    output logic     done_take,
    output logic     susp_take
);

    wr_kind_e kind_q;
    logic     can_susp;
    logic     resume_take;

    always_comb begin
        can_susp    = (kind_q == WK_ERASE) ? !erase_susp : !prog_susp;
        done_take   = wr_done && busy && !start_long;
        susp_take   = ev_suspend && busy && !start_long && !wr_done && can_susp;
        resume_take = ev_resume && !busy && !start_long && (prog_susp || erase_susp);
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            busy       <= 1'b0;
            kind_q     <= WK_PROG;
            erase_susp <= 1'b0;
            prog_susp  <= 1'b0;
        end else if (start_long) begin
            busy   <= 1'b1;
            kind_q <= start_kind;
        end else if (done_take) begin
            busy <= 1'b0;
        end else if (susp_take) begin
            busy <= 1'b0;
            if (kind_q == WK_ERASE) erase_susp <= 1'b1;
            else                    prog_susp  <= 1'b1;
        end else if (resume_take) begin
            busy <= 1'b1;
            if (prog_susp) begin
                prog_susp <= 1'b0;
                kind_q    <= WK_PROG;
            end else begin
                erase_susp <= 1'b0;
                kind_q     <= WK_ERASE;
            end
        end
    end

    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst_all)
        start_long |=> busy);

    p_erase_susp_r6: assert property (@(posedge clk) disable iff (rst_all)
        (ev_suspend && busy && kind_q == WK_ERASE && !erase_susp && !wr_done && !start_long)
        |=> (erase_susp && !busy));

    p_resume_order_r7: assert property (@(posedge clk) disable iff (rst_all)
        (ev_resume && !busy && prog_susp && erase_susp && !start_long)
        |=> (!prog_susp && erase_susp && busy));

    p_resume_busy_r7: assert property (@(posedge clk) disable iff (rst_all)
        (ev_resume && busy && !wr_done && !ev_suspend)
        |=> ($stable(prog_susp) && $stable(erase_susp)));

endmodule

// File: rtl/fsc_latch_bank.sv
module fsc_latch_bank (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic nv_sid_locked,
    input  logic ev_wren,
    input  logic ev_wrdi,
    input  logic clear_evt,
    input  logic freeze_set,
    input  logic sid_set,
    output logic wel,
    output logic prot_frozen,
    output logic sid_locked
);

    always_ff @(posedge clk) begin
        if (rst || por)                 wel <= 1'b0;
        else if (clear_evt || ev_wrdi)  wel <= 1'b0;
        else if (ev_wren)               wel <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por)             prot_frozen <= 1'b0;
        else if (freeze_set) prot_frozen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por)          sid_locked <= nv_sid_locked;
        else if (sid_set) sid_locked <= 1'b1;
    end

    p_freeze_sticky_r8: assert property (@(posedge clk) disable iff (por)
        prot_frozen |=> prot_frozen);

    p_sid_sticky_r9: assert property (@(posedge clk) disable iff (por)
        sid_locked |=> sid_locked);

    p_sid_reload_r1: assert property (@(posedge clk)
        (por && nv_sid_locked) |=> sid_locked);

    p_wel_soft_rst_r11: assert property (@(posedge clk)
        rst |=> !wel);

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import fsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                por,
    input  logic                nv_sid_locked,
    input  logic                ev_wren,
    input  logic                ev_wrdi,
    input  logic                mod_req,
    input  logic [OP_W-1:0]     mod_op,
    input  logic                wr_done,
    input  logic                ev_suspend,
    input  logic                ev_resume,
    output logic [STATUS_W-1:0] status,
    output logic                write_ok,
    output logic                mod_accept,
    output logic                sid_commit
);

    logic     wel, busy, erase_susp, prog_susp, prot_frozen, sid_locked;
    logic     start_long, imm_done, freeze_set, sid_set;
    logic     done_take, susp_take;
    wr_kind_e start_kind;
    status_t  sts;

    fsc_cmd_gate u_gate (
        .mod_req     (mod_req),
        .mod_op      (mod_op_e'(mod_op)),
        .wel         (wel),
        .busy        (busy),
        .prot_frozen (prot_frozen),
        .sid_locked  (sid_locked),
        .accept      (mod_accept),
        .start_long  (start_long),
        .start_kind  (start_kind),
        .imm_done    (imm_done),
        .freeze_set  (freeze_set),
        .sid_set     (sid_set)
    );

    fsc_write_track u_track (
        .clk        (clk),
        .rst_all    (rst || por),
        .start_long (start_long),
        .start_kind (start_kind),
        .wr_done    (wr_done),
        .ev_suspend (ev_suspend),
        .ev_resume  (ev_resume),
        .busy       (busy),
        .erase_susp (erase_susp),
        .prog_susp  (prog_susp),
        .done_take  (done_take),
        .susp_take  (susp_take)
    );

    fsc_latch_bank u_latch (
        .clk           (clk),
        .rst           (rst),
        .por           (por),
        .nv_sid_locked (nv_sid_locked),
        .ev_wren       (ev_wren),
        .ev_wrdi       (ev_wrdi),
        .clear_evt     (imm_done || done_take || susp_take),
        .freeze_set    (freeze_set),
        .sid_set       (sid_set),
        .wel           (wel),
        .prot_frozen   (prot_frozen),
        .sid_locked    (sid_locked)
    );

    always_comb begin
        sts            = '0;
        sts.busy       = busy;
        sts.sid_locked = sid_locked;
        sts.prot_frozen = prot_frozen;
        sts.prog_susp  = prog_susp;
        sts.erase_susp = erase_susp;
        sts.wel        = wel;
        status         = sts;
        write_ok       = wel && !busy;
        sid_commit     = sid_set;
    end

    p_reject_r3: assert property (@(posedge clk) disable iff (rst || por)
        mod_accept |-> (status[1] && !status[7]));

    p_imm_clears_r5: assert property (@(posedge clk) disable iff (rst || por)
        (mod_accept && mod_op >= 3'd5) |=> (!status[1] && !status[7]));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (rst || por)
        (wr_done && status[7] && !mod_req) |=> (!status[7] && !status[1]));

    p_reserved_r1: assert property (@(posedge clk) disable iff (rst || por)
        (!status[0] && !status[6]));

endmodule

// File: tb/flash_status_ctrl_bench.sv
module flash_status_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic       nv = 1'b0;
    logic       ev_wren = 1'b0, ev_wrdi = 1'b0, mod_req = 1'b0;
    logic [2:0] mod_op = 3'd0;
    logic       wr_done = 1'b0, ev_suspend = 1'b0, ev_resume = 1'b0;
    logic [7:0] status;
    logic       write_ok, mod_accept, sid_commit;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic m_wel = 0, m_busy = 0, m_erase = 0, m_wse = 0, m_wsp = 0, m_lock = 0, m_sec = 0;

    localparam int EV_NONE = 0, EV_WREN = 1, EV_WRDI = 2, EV_REQ = 3, EV_DONE = 4,
                   EV_SUSP = 5, EV_RES = 6, EV_RST = 7, EV_POR = 8;

    always #5 clk = ~clk;

    flash_status_ctrl u_flash_status_ctrl (
        .clk(clk), .rst(rst), .por(por), .nv_sid_locked(nv),
        .ev_wren(ev_wren), .ev_wrdi(ev_wrdi), .mod_req(mod_req), .mod_op(mod_op),
        .wr_done(wr_done), .ev_suspend(ev_suspend), .ev_resume(ev_resume),
        .status(status), .write_ok(write_ok), .mod_accept(mod_accept),
        .sid_commit(sid_commit)
    );

    function automatic logic [7:0] exp_status();
        return {m_busy, 1'b0, m_sec, m_lock, m_wsp, m_wse, m_wel, 1'b0};
    endfunction

    function automatic logic exp_accept(logic [2:0] op);
        logic hit;
        hit = ((op == 3'd4 || op == 3'd7) && m_sec) || ((op == 3'd5 || op == 3'd6) && m_lock);
        return m_wel && !m_busy && !hit;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic model_update(input int ev, input logic [2:0] op, input logic acc);
        if (ev == EV_POR) begin
            m_wel = 0; m_busy = 0; m_wse = 0; m_wsp = 0; m_lock = 0; m_sec = nv; m_erase = 0;
        end else if (ev == EV_RST) begin
            m_wel = 0; m_busy = 0; m_wse = 0; m_wsp = 0; m_erase = 0;
        end else begin
            case (ev)
                EV_WREN: m_wel = 1;
                EV_WRDI: m_wel = 0;
                EV_REQ: if (acc) begin
                    if (op <= 3'd4) begin
                        m_busy = 1; m_erase = (op >= 3'd1 && op <= 3'd3);
                    end else begin
                        m_wel = 0;
                        if (op == 3'd6) m_lock = 1;
                        if (op == 3'd7) begin m_sec = 1; nv = 1'b1; end
                    end
                end
                EV_DONE: if (m_busy) begin m_busy = 0; m_wel = 0; end
                EV_SUSP: if (m_busy) begin
                    if (m_erase && !m_wse)       begin m_wse = 1; m_busy = 0; m_wel = 0; end
                    else if (!m_erase && !m_wsp) begin m_wsp = 1; m_busy = 0; m_wel = 0; end
                end
                EV_RES: if (!m_busy) begin
                    if (m_wsp)      begin m_wsp = 0; m_busy = 1; m_erase = 0; end
                    else if (m_wse) begin m_wse = 0; m_busy = 1; m_erase = 1; end
                end
                default: ;
            endcase
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input int ev, input logic [2:0] op, input string tag);
        logic acc;
        ev_wren = (ev == EV_WREN); ev_wrdi = (ev == EV_WRDI); mod_req = (ev == EV_REQ);
        wr_done = (ev == EV_DONE); ev_suspend = (ev == EV_SUSP); ev_resume = (ev == EV_RES);
        rst = (ev == EV_RST); por = (ev == EV_POR); mod_op = op;
        #1;
        acc = (ev == EV_REQ) && exp_accept(op);
        check(mod_accept == acc, tag, "accept", {7'd0, mod_accept}, {7'd0, acc});
        check(sid_commit == (acc && op == 3'd7), tag, "sid_commit",
              {7'd0, sid_commit}, {7'd0, acc && op == 3'd7});
        @(posedge clk);
        model_update(ev, op, acc);
        @(negedge clk);
        ev_wren = 0; ev_wrdi = 0; mod_req = 0; wr_done = 0;
        ev_suspend = 0; ev_resume = 0; rst = 0; por = 0;
        check(status == exp_status(), tag, "status", status, exp_status());
        check(write_ok == (m_wel && !m_busy), tag, "write_ok",
              {7'd0, write_ok}, {7'd0, m_wel && !m_busy});
    endtask

    function automatic string tag_of(int ev);
        case (ev)
            EV_WREN, EV_WRDI: return "R2";
            EV_REQ:  return "R3";
            EV_DONE: return "R4";
            EV_SUSP: return "R6";
            EV_RES:  return "R7";
            EV_RST:  return "R11";
            EV_POR:  return "R1";
            default: return "R10";
        endcase
    endfunction

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        @(negedge clk);
        @(negedge clk);
        step(EV_POR, 3'd0, "R1");                 // power-up state 00
        step(EV_REQ, 3'd0, "R3");                 // no WEL: reject
        step(EV_WREN, 3'd0, "R2");                // 02, write_ok R10
        step(EV_REQ, 3'd1, "R4");                 // sector erase: 82
        step(EV_REQ, 3'd0, "R3");                 // busy: reject
        step(EV_SUSP, 3'd0, "R6");                // 04
        step(EV_SUSP, 3'd0, "R12");               // idle suspend ignored
        step(EV_WREN, 3'd0, "R2");
        step(EV_REQ, 3'd0, "R4");                 // program inside erase suspend: 86
        step(EV_SUSP, 3'd0, "R6");                // 0C
        step(EV_RES, 3'd0, "R7");                 // program first: 84
        step(EV_RES, 3'd0, "R7");                 // ignored while busy
        step(EV_DONE, 3'd0, "R4");                // 04
        step(EV_DONE, 3'd0, "R12");               // idle done ignored
        step(EV_RES, 3'd0, "R7");                 // erase resumes: 80
        step(EV_DONE, 3'd0, "R4");                // 00
        step(EV_RES, 3'd0, "R12");                // nothing suspended
        step(EV_WREN, 3'd0, "R2");
        step(EV_REQ, 3'd6, "R8");                 // freeze: 10, WEL cleared R5
        step(EV_WREN, 3'd0, "R2");
        step(EV_REQ, 3'd5, "R8");                 // frozen: reject
        step(EV_REQ, 3'd6, "R8");                 // frozen: reject
        step(EV_RST, 3'd0, "R11");                // keeps bit 4
        step(EV_WREN, 3'd0, "R2");
        step(EV_REQ, 3'd7, "R9");                 // lockout: 30, commit pulse
        step(EV_WREN, 3'd0, "R2");
        step(EV_REQ, 3'd4, "R9");                 // locked id: reject
        step(EV_REQ, 3'd7, "R9");                 // reject
        step(EV_REQ, 3'd5, "R5");                 // frozen: reject
        step(EV_POR, 3'd0, "R9");                 // 20: lock survives, freeze gone
        step(EV_WREN, 3'd0, "R2");
        step(EV_REQ, 3'd5, "R5");                 // prot write now accepted: 20
        step(EV_WRDI, 3'd0, "R2");
        step(EV_POR, 3'd0, "R1");
        for (int i = 0; i < 4000; i++) begin
            int r, ev;
            r = $urandom_range(0, 99);
            if      (r < 14) ev = EV_WREN;
            else if (r < 18) ev = EV_WRDI;
            else if (r < 50) ev = EV_REQ;
            else if (r < 64) ev = EV_DONE;
            else if (r < 76) ev = EV_SUSP;
            else if (r < 88) ev = EV_RES;
            else if (r < 90) ev = EV_RST;
            else if (r < 91) ev = EV_POR;
            else             ev = EV_NONE;
            step(ev, 3'($urandom_range(0, 7)), tag_of(ev));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule